// File: doc/BRIEF.md
# Two-Wire Wiper Control Slave

This block is the command side of a digital potentiometer. It listens on a two-wire serial bus (SCL/SDA), sampled from a fast system clock. It detects START, repeated START and STOP conditions and accepts transactions sent to its 7-bit device address. The top five bits of that address are fixed by a parameter. The low two bits come from two address pins, so four such devices can share one bus.

After the address, the instruction byte selects an operation: write the 8-bit wiper, set or clear write protection, write or read a byte of the nonvolatile array, copy the wiper to the array, or copy the array back into the wiper. A read is done as an address-plus-instruction write, then a repeated START, then the address with the read bit set. The array itself sits outside the block. It is reached through a single-request port: the block raises a request and holds it until the array acknowledges. SDA is driven open-drain: a constant-low data output plus an output enable.

Control is one state machine. Its states are:
- S_IDLE: waiting for START.
- S_ADDR, S_INSTR, S_WDATA: receiving a byte.
- S_ACK_SETUP: waiting for the falling edge after bit 8.
- S_ACK_HOLD: pulling SDA low for the acknowledge bit.
- S_RD_SHIFT: sending a byte.
- S_RD_ACK: sampling the master's acknowledge.
- S_RD_NEXT: reloading for another read byte.
- S_IGNORE: not addressed; waiting for the next bus condition.

Its transitions are:
- START in any state leads to S_ADDR. STOP in any state leads to S_IDLE.
- After 8 bits, S_ADDR goes to S_ACK_SETUP on a match and to S_IGNORE otherwise.
- After 8 bits, S_INSTR and S_WDATA go to S_ACK_SETUP.
- S_ACK_SETUP goes to S_ACK_HOLD on an SCL fall.
- S_ACK_HOLD goes to its return state on an SCL fall. The return state is S_INSTR, S_WDATA or S_RD_SHIFT.
- S_RD_SHIFT goes to S_RD_ACK on the fall after the 8th bit.
- S_RD_ACK goes to S_RD_NEXT on an ACK and to S_IDLE on a NACK.
- S_RD_NEXT goes to S_RD_SHIFT on an SCL fall.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset, sda_oe is 0, mem_req is 0, the wiper holds 8'h80 and write protection is off.
- R2: The device answers only the address {5'b01011, addr_pins}, with addr_pins taken while reset is asserted. It acknowledges by pulling SDA low on the ninth clock. For any other address it gives no acknowledge and the rest of the transaction has no effect.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START restarts the address phase and keeps the latched instruction. SDA is released after STOP.
- R4: In the instruction byte, bits 7:5 are the opcode and bits 4:0 are a memory address. The opcodes are 000 no-op, 001 wiper, 010 memory byte, 011 protection, 101 store, 110 restore. The instruction byte is always acknowledged, and a no-op changes nothing.
- R5: With opcode 001, every data byte after the instruction (MSB first) loads the wiper, until STOP.
- R6: With opcode 011, data bit 0 set to 1 enables protection and 0 disables it. While protection is on, wiper writes, memory writes and stores are acknowledged but have no effect.
- R7: Opcode 101 writes the wiper into memory location 0. Opcode 110 reads location 0 into the wiper. Neither takes a data byte.
- R8: With a read address after the instruction, the block returns the wiper byte for any opcode except 010. For opcode 010 it returns the memory byte at the instruction's address. Read data changes only after an SCL falling edge.
- R9: Each read byte the master acknowledges under opcode 010 advances the memory address by one, so 5'b11110 is followed by 5'b11111. A NACK ends the read.
- R10: A data byte under opcode 010 is written to the addressed memory location. Locations 5'b11110 and 5'b11111 hold the tolerance and are never written.
- R11: mem_req stays high with mem_we, mem_addr and mem_wdata stable until mem_ack, then drops.
- R12: sda_oe only becomes active while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; address pins are sampled while low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Open-drain data value, always 0 |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| addr_pins | input | 2 | Low two bits of the device address |
| wiper | output | 8 | Current wiper setting |
| mem_req | output | 1 | Array access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 5 | Array location |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ack |
| mem_ack | input | 1 | Array completes the request |

## Verification
Some properties are checked on every cycle:
- Array requests stay stable until acknowledged (R11).
- An array write is never aimed at a tolerance location (R10) and never happens under protection (R6).
- The wiper never changes under protection except by a restore (R6).
- SDA is only pulled low while SCL is low (R12), and it is released in S_IDLE (R3).

Other behaviour only the directed scenarios can show:
- Address matching and acknowledge values (R2).
- Opcode meaning and data values (R4, R5, R7).
- Read bytes that come back, pointer stepping (R8, R9).
- A protected write leaves the wiper unchanged (R6).

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'b000,
        OP_WIPER   = 3'b001,
        OP_MEM     = 3'b010,
        OP_PROTECT = 3'b011,
        OP_RSVD4   = 3'b100,
        OP_STORE   = 3'b101,
        OP_RESTORE = 3'b110,
        OP_RSVD7   = 3'b111
    } pot_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_INSTR,
        S_WDATA,
        S_ACK_SETUP,
        S_ACK_HOLD,
        S_RD_SHIFT,
        S_RD_ACK,
        S_RD_NEXT,
        S_IGNORE
    } pot_state_e;

    typedef struct packed {
        logic wr_wiper;
        logic mem;
        logic protect;
        logic store;
        logic restore;
    } pot_cmd_t;

endpackage

// File: rtl/pot_line_sync.sv
module pot_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain;

        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-1:0], raw[g]};
        end

        assign level[g] = chain[STAGES-1];
        assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
        assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/pot_cmd_decode.sv
module pot_cmd_decode
    import pot_i2c_pkg::*;
(
    input  pot_op_e  op,
    output pot_cmd_t cmd
);
    always_comb begin
        cmd = '0;
        case (op)
            OP_WIPER:   cmd.wr_wiper = 1'b1;
            OP_MEM:     cmd.mem      = 1'b1;
            OP_PROTECT: cmd.protect  = 1'b1;
            OP_STORE:   cmd.store    = 1'b1;
            OP_RESTORE: cmd.restore  = 1'b1;
            default:    cmd          = '0;
        endcase
    end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
    import pot_i2c_pkg::*;
#(
    parameter int               ADDR_HI_W   = 5,
    parameter logic [4:0]       ADDR_HI     = 5'b01011,
    parameter int               PIN_W       = 2,
    parameter int               OP_W        = 3,
    parameter logic [7:0]       WIPER_RESET = 8'h80,
    parameter int               SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         sda_o,
    output logic         sda_oe,
    input  logic [1:0]   addr_pins,
    output logic [7:0]   wiper,
    output logic         mem_req,
    output logic         mem_we,
    output logic [4:0]   mem_addr,
    output logic [7:0]   mem_wdata,
    input  logic [7:0]   mem_rdata,
    input  logic         mem_ack
);
    localparam int BYTE_W = ADDR_HI_W + PIN_W + 1;
    localparam int MEM_AW = BYTE_W - OP_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [MEM_AW-1:0] TOL_BASE   = MEM_AW'((1 << MEM_AW) - 2);
    localparam logic [MEM_AW-1:0] WIPER_SLOT = '0;

    logic [1:0] lvl, rs, fl;
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;

    pot_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
        .level(lvl), .rise(rs), .fall(fl)
    );

    assign scl_lvl  = lvl[0];
    assign sda_lvl  = lvl[1];
    assign scl_rise = rs[0];
    assign scl_fall = fl[0];
    assign start_c  = fl[1] & scl_lvl & ~scl_rise;
    assign stop_c   = rs[1] & scl_lvl & ~scl_rise;

    pot_state_e          state, state_nx, ret_state;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-2:0]   shreg;
    logic [BYTE_W-1:0]   rx_byte, tx, wiper_q;
    logic                drive_low, wp_q, cmd_go, dst_wiper;
    logic [PIN_W-1:0]    dev_pins;
    logic [MEM_AW-1:0]   ptr, ptr_nx;
    pot_op_e             op_q;
    pot_cmd_t            cmd_q;
    logic                last_bit, addr_hit;

    pot_cmd_decode u_dec (.op(op_q), .cmd(cmd_q));

    assign rx_byte  = {shreg, sda_lvl};
    assign last_bit = scl_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign addr_hit = (rx_byte[BYTE_W-1:1] == {ADDR_HI, dev_pins});
    assign ptr_nx   = ptr + MEM_AW'(1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_c)     state_nx = S_ADDR;
        else if (stop_c) state_nx = S_IDLE;
        else begin
            unique case (state)
                S_IDLE, S_IGNORE: state_nx = state;
                S_ADDR:      if (last_bit) state_nx = addr_hit ? S_ACK_SETUP : S_IGNORE;
                S_INSTR,
                S_WDATA:     if (last_bit) state_nx = S_ACK_SETUP;
                S_ACK_SETUP: if (scl_fall) state_nx = S_ACK_HOLD;
                S_ACK_HOLD:  if (scl_fall) state_nx = ret_state;
                S_RD_SHIFT:  if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) state_nx = S_RD_ACK;
                S_RD_ACK:    if (scl_rise) state_nx = sda_lvl ? S_IDLE : S_RD_NEXT;
                S_RD_NEXT:   if (scl_fall) state_nx = S_RD_SHIFT;
                default:     state_nx = S_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_state <= S_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx        <= '0;
            drive_low <= 1'b0;
            op_q      <= OP_NOP;
            ptr       <= '0;
            wp_q      <= 1'b0;
            cmd_go    <= 1'b0;
            wiper_q   <= WIPER_RESET;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            dst_wiper <= 1'b0;
            dev_pins  <= addr_pins;
        end else begin
            if (mem_req && mem_ack) begin
                mem_req <= 1'b0;
                if (!mem_we) begin
                    if (dst_wiper) wiper_q <= mem_rdata;
                    else           tx      <= mem_rdata;
                end
            end
            if (start_c || stop_c) begin
                bit_cnt   <= '0;
                drive_low <= 1'b0;
                cmd_go    <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_INSTR, S_WDATA: if (scl_rise) begin
                        shreg   <= rx_byte[BYTE_W-2:0];
                        bit_cnt <= last_bit ? '0 : bit_cnt + CNT_W'(1);
                        if (last_bit && state == S_ADDR && addr_hit) begin
                            if (rx_byte[0]) begin
                                ret_state <= S_RD_SHIFT;
                                if (cmd_q.mem) begin
                                    mem_req <= 1'b1; mem_we <= 1'b0;
                                    mem_addr <= ptr; dst_wiper <= 1'b0;
                                end else tx <= wiper_q;
                            end else ret_state <= S_INSTR;
                        end
                        if (last_bit && state == S_INSTR) begin
                            op_q      <= pot_op_e'(rx_byte[BYTE_W-1 -: OP_W]);
                            ptr       <= rx_byte[MEM_AW-1:0];
                            ret_state <= S_WDATA;
                            cmd_go    <= 1'b1;
                        end
                        if (last_bit && state == S_WDATA) begin
                            if (cmd_q.wr_wiper && !wp_q) wiper_q <= rx_byte;
                            if (cmd_q.protect) wp_q <= rx_byte[0];
                            if (cmd_q.mem && !wp_q && ptr < TOL_BASE) begin
                                mem_req <= 1'b1; mem_we <= 1'b1;
                                mem_addr <= ptr; mem_wdata <= rx_byte;
                            end
                        end
                    end
                    S_ACK_SETUP: if (scl_fall) begin
                        drive_low <= 1'b1;
                        if (cmd_go) begin
                            cmd_go <= 1'b0;
                            if (cmd_q.store && !wp_q) begin
                                mem_req <= 1'b1; mem_we <= 1'b1;
                                mem_addr <= WIPER_SLOT; mem_wdata <= wiper_q;
                            end
                            if (cmd_q.restore) begin
                                mem_req <= 1'b1; mem_we <= 1'b0;
                                mem_addr <= WIPER_SLOT; dst_wiper <= 1'b1;
                            end
                        end
                    end
                    S_ACK_HOLD: if (scl_fall) begin
                        bit_cnt   <= '0;
                        drive_low <= (ret_state == S_RD_SHIFT) ? ~tx[BYTE_W-1] : 1'b0;
                    end
                    S_RD_SHIFT: begin
                        if (scl_rise) bit_cnt <= bit_cnt + CNT_W'(1);
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W)) drive_low <= 1'b0;
                            else begin
                                tx        <= {tx[BYTE_W-2:0], 1'b0};
                                drive_low <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    S_RD_ACK: if (scl_rise && !sda_lvl) begin
                        if (cmd_q.mem) begin
                            ptr     <= ptr_nx;
                            mem_req <= 1'b1; mem_we <= 1'b0;
                            mem_addr <= ptr_nx; dst_wiper <= 1'b0;
                        end else tx <= wiper_q;
                    end
                    S_RD_NEXT: if (scl_fall) begin
                        bit_cnt   <= '0;
                        drive_low <= ~tx[BYTE_W-1];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_o  = 1'b0;
    assign sda_oe = drive_low;
    assign wiper  = wiper_q;
endmodule

// File: rtl/pot_i2c_checks.sv
module pot_i2c_checks
    import pot_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       sda_oe,
    input pot_state_e state,
    input logic       wp_q,
    input logic       dst_wiper,
    input logic [7:0] wiper,
    input logic       mem_req,
    input logic       mem_ack,
    input logic       mem_we,
    input logic [4:0] mem_addr,
    input logic [7:0] mem_wdata
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    a_r10_tol_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr < 5'b11110));

    a_r6_no_write_protected: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !wp_q);

    a_r6_wiper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wp_q) && (wiper != $past(wiper)))
            |-> $past(mem_req && mem_ack && !mem_we && dst_wiper));

    a_r12_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(sda_oe)) |-> !scl_lvl);

    a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);
endmodule

bind wiper_i2c_slave pot_i2c_checks u_checks (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
    .state(state), .wp_q(wp_q), .dst_wiper(dst_wiper), .wiper(wiper),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/wiper_i2c_slave_test.sv
module wiper_i2c_slave_test;
    localparam int Q = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1;
    logic       sda_o, sda_oe, sda_line;
    logic [7:0] wiper, mem_wdata, mem_rdata = '0;
    logic       mem_req, mem_we, mem_ack = 1'b0;
    logic [4:0] mem_addr;
    logic [1:0] pins = 2'b10;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    wiper_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .addr_pins(pins), .wiper(wiper),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    logic [7:0] mem [32];
    logic       poke_en = 1'b0;
    logic [4:0] poke_a = '0;
    logic [7:0] poke_d = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 3);
            mem[5]  <= 8'hA5;
            mem[30] <= 8'h1C;
            mem[31] <= 8'h0F;
            mem_ack <= 1'b0;
        end else if (poke_en) begin
            mem[poke_a] <= poke_d;
        end else if (mem_req && !mem_ack) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
            mem_ack <= 1'b1;
        end else mem_ack <= 1'b0;
    end

    int bad_rise = 0;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe && !oe_prev && scl) bad_rise++;
        oe_prev <= sda_oe;
    end

    int n_chk = 0, n_bad = 0;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [4:0] a, input logic [7:0] d);
        poke_a = a; poke_d = d; poke_en = 1'b1;
        wt(1);
        poke_en = 1'b0;
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wt(2); sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0;
        end
        wt(2); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q/2);
        ack = ~sda_line;
        wt(Q/2); scl = 1'b0;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl = 1'b1; wt(Q/2); b[i] = sda_line; wt(Q/2); scl = 1'b0;
        end
        wt(2); sda_m = ~mack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(2); sda_m = 1'b1;
    endtask

    task automatic write_cmd(input logic [7:0] ins, input logic [7:0] dat);
        logic a;
        i2c_start; wbyte(8'h5C, a); wbyte(ins, a); wbyte(dat, a); i2c_stop;
    endtask

    task automatic short_cmd(input logic [7:0] ins);
        logic a;
        i2c_start; wbyte(8'h5C, a); wbyte(ins, a); i2c_stop; wt(5);
    endtask

    task automatic t_reset;
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 wiper after reset", wiper, 8'h80);
        check("R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_write_wiper;
        logic a0, a1, a2;
        i2c_start;
        wbyte(8'h5C, a0); check("R2 address ack", a0, 1);
        wbyte(8'h20, a1); check("R4 instruction ack", a1, 1);
        wbyte(8'h3C, a2); check("R5 data ack", a2, 1);
        check("R5 wiper first byte", wiper, 8'h3C);
        wbyte(8'h11, a2); check("R5 wiper repeated byte", wiper, 8'h11);
        wbyte(8'hEE, a2); check("R5 wiper third byte", wiper, 8'hEE);
        i2c_stop; wt(5);
        check("R3 sda released after stop", sda_oe, 0);
    endtask

    task automatic t_wrong_addr;
        logic a;
        i2c_start;
        wbyte(8'h58, a); check("R2 foreign address no ack", a, 0);
        wbyte(8'h20, a); wbyte(8'h55, a);
        i2c_stop; wt(5);
        check("R2 foreign transaction ignored", wiper, 8'hEE);
    endtask

    task automatic t_nop;
        write_cmd(8'h00, 8'h12); wt(5);
        check("R4 no-op leaves wiper", wiper, 8'hEE);
    endtask

    task automatic t_read_wiper;
        logic a; logic [7:0] b;
        i2c_start; wbyte(8'h5C, a); wbyte(8'h20, a);
        i2c_start; wbyte(8'h5D, a);
        check("R3 repeated start read ack", a, 1);
        rbyte(1'b0, b); i2c_stop;
        check("R8 read wiper", b, 8'hEE);
    endtask

    task automatic t_read_tol;
        logic a; logic [7:0] b;
        i2c_start; wbyte(8'h5C, a); wbyte(8'h5E, a);
        i2c_start; wbyte(8'h5D, a);
        rbyte(1'b1, b); check("R9 tolerance first byte", b, 8'h1C);
        rbyte(1'b0, b); check("R9 tolerance stepped byte", b, 8'h0F);
        i2c_stop;
    endtask

    task automatic t_mem_read;
        logic a; logic [7:0] b;
        i2c_start; wbyte(8'h5C, a); wbyte(8'h45, a);
        i2c_start; wbyte(8'h5D, a);
        rbyte(1'b0, b); i2c_stop;
        check("R8 read memory location 5", b, 8'hA5);
    endtask

    task automatic t_mem_write;
        write_cmd(8'h43, 8'h5A); wt(5);
        check("R10 memory write location 3", mem[3], 8'h5A);
        write_cmd(8'h5E, 8'h77); wt(5);
        check("R10 tolerance not written", mem[30], 8'h1C);
    endtask

    task automatic t_store_restore;
        write_cmd(8'h20, 8'h42);
        short_cmd(8'hA0);
        check("R7 store wiper to location 0", mem[0], 8'h42);
        poke(5'd0, 8'h99);
        short_cmd(8'hC0);
        check("R7 restore location 0 to wiper", wiper, 8'h99);
    endtask

    task automatic t_protect;
        logic a0, a1, a2;
        write_cmd(8'h60, 8'h01);
        i2c_start; wbyte(8'h5C, a0); wbyte(8'h20, a1); wbyte(8'h77, a2); i2c_stop; wt(5);
        check("R6 protected write still acked", a2, 1);
        check("R6 protected wiper unchanged", wiper, 8'h99);
        poke(5'd0, 8'h13);
        short_cmd(8'hA0);
        check("R6 protected store ignored", mem[0], 8'h13);
        write_cmd(8'h43, 8'h66); wt(5);
        check("R6 protected memory write ignored", mem[3], 8'h5A);
        write_cmd(8'h60, 8'h00);
        write_cmd(8'h20, 8'h77); wt(5);
        check("R6 write after unprotect", wiper, 8'h77);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

    initial begin
        wt(10);
        rst_n = 1'b1;
        pins = 2'b00;
        wt(10);
        t_reset;
        t_write_wiper;
        t_wrong_addr;
        t_nop;
        t_read_wiper;
        t_read_tol;
        t_mem_read;
        t_mem_write;
        t_store_restore;
        t_protect;
        wt(10);
        check("R11 request released after acknowledge", mem_req, 0);
        check("R12 no pull-down while SCL high", bad_rise, 0);
        summary;
        $finish;
    end
endmodule